// File: doc/BRIEF.md
# Dual-Bus Code/System Address Router

This block sits between a core's two request sources, an instruction prefetch port and a load/store port, and two downstream buses: a code bus and a system bus. The address of each request picks its bus. A fixed split point divides the address space. Either source may reach either region, so code can run from the system region and data can be read from or written to the code region. Traffic from the two sources flows in parallel whenever they land on different buses.

When both sources want the same bus, a fixed-priority arbiter serves the load/store port first and the speculative prefetch waits. There is one exception to that priority. If a prefetch has already been presented to a bus and has not yet been taken, the bus keeps presenting it, so that a request on a bus never changes before its handshake completes.

Every request and response channel is valid/ready. A master raises valid and holds its address, write flag and write data steady until it sees ready in the same cycle. Response channels follow the same rule in the other direction. Each bus carries at most one transfer between its request handshake and its response handshake. Each source port has at most one transfer outstanding.

Top module: `rtr_dual_bus`

## Requirements
- R1: A request whose address is below 0x2000_0000 is presented on the code bus only, from either source port.
- R2: A request whose address is 0x2000_0000 or above is presented on the system bus only, from either source port.
- R3: When the prefetch and load/store requests target different buses, both buses are idle and both slaves are ready, both requests are accepted in the same cycle.
- R4: When both source ports present new requests for the same idle bus, the load/store request is presented and accepted, and prefetch ready stays low.
- R5: A request a bus has presented without acceptance is presented again next cycle with identical address, write flag and write data. This holds even if a load/store request arrives for that bus meanwhile.
- R6: After a bus accepts a request, it presents no new request until the slave's response handshake on that bus completes.
- R7: A source port with a transfer outstanding sees ready low on its request channel until that transfer's response handshake completes.
- R8: A bus response reaches only the source port that owns the transfer on that bus, and the bus's response ready mirrors that port's response ready. A response valid on a bus with no transfer in flight gets ready low and reaches neither port.
- R9: A prefetch request is presented with write flag 0 and write data 0.
- R10: Out of reset, with no input active, no request valid, request ready, response valid or response ready output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fch_req_valid | input | 1 | Prefetch request valid |
| fch_req_ready | output | 1 | Prefetch request accepted this cycle |
| fch_req_addr | input | ADDR_W | Prefetch address |
| fch_rsp_valid | output | 1 | Prefetch response valid |
| fch_rsp_ready | input | 1 | Prefetch port takes the response |
| fch_rsp_data | output | DATA_W | Prefetch response data |
| ldst_req_valid | input | 1 | Load/store request valid |
| ldst_req_ready | output | 1 | Load/store request accepted this cycle |
| ldst_req_addr | input | ADDR_W | Load/store address |
| ldst_req_write | input | 1 | 1 for a store, 0 for a load |
| ldst_req_wdata | input | DATA_W | Store data |
| ldst_rsp_valid | output | 1 | Load/store response valid |
| ldst_rsp_ready | input | 1 | Load/store port takes the response |
| ldst_rsp_data | output | DATA_W | Load/store response data |
| code_req_valid | output | 1 | Code bus request valid |
| code_req_ready | input | 1 | Code slave accepts the request |
| code_req_addr | output | ADDR_W | Code bus address |
| code_req_write | output | 1 | Code bus write flag |
| code_req_wdata | output | DATA_W | Code bus write data |
| code_rsp_valid | input | 1 | Code slave response valid |
| code_rsp_ready | output | 1 | Code bus response taken |
| code_rsp_data | input | DATA_W | Code slave response data |
| sys_req_valid | output | 1 | System bus request valid |
| sys_req_ready | input | 1 | System slave accepts the request |
| sys_req_addr | output | ADDR_W | System bus address |
| sys_req_write | output | 1 | System bus write flag |
| sys_req_wdata | output | DATA_W | System bus write data |
| sys_rsp_valid | input | 1 | System slave response valid |
| sys_rsp_ready | output | 1 | System bus response taken |
| sys_rsp_data | input | DATA_W | System slave response data |

## Verification
The assertions check on every cycle the bus-side properties. They confirm that a stalled bus request stays unchanged, that a bus goes quiet after a request handshake, and that a prefetch drives no write. They also confirm that the prefetch port never owns both buses, that same-bus contention never lets a fresh prefetch through, and that requests on different buses proceed together. The bench's scenarios show the rest. That covers end-to-end routing of the split-point addresses, the response data each port gets back from the right slave, and stray responses on an idle bus being dropped. It also covers a waiting prefetch keeping its bus against a later load/store, and a busy port being refused a second request.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FCH  = 2'd1,
    OWN_DAT  = 2'd2
  } owner_e;

  localparam int NUM_BUS  = 2;
  localparam int BUS_CODE = 0;
  localparam int BUS_SYS  = 1;
endpackage

// File: rtl/rtr_region_decode.sv
module rtr_region_decode #(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              to_sys
);
  // Lower region feeds the code bus, everything from the limit up the system bus.
  assign to_sys = (addr >= CODE_LIMIT);
endmodule

// File: rtl/rtr_lane.sv
module rtr_lane
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fch_want,
  input  logic              dat_want,
  input  logic [ADDR_W-1:0] fch_addr,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic              dat_write,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_req_write,
  output logic [DATA_W-1:0] bus_req_wdata,
  output logic              fch_accept,
  output logic              dat_accept,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  input  logic              fch_rsp_ready,
  input  logic              dat_rsp_ready,
  output logic              fch_rsp_hit,
  output logic              dat_rsp_hit,
  output logic              fch_owns,
  output logic              dat_owns,
  output logic              fch_held
);
  owner_e owner_q;
  logic   hold_q;
  logic   free, pick_fch, pick_dat, rsp_done;

  assign free     = (owner_q == OWN_NONE);
  // A prefetch already on the bus keeps it; otherwise load/store comes first.
  assign pick_fch = free & (hold_q | (fch_want & ~dat_want));
  assign pick_dat = free & ~hold_q & dat_want;

  assign bus_req_valid = pick_fch | pick_dat;
  assign bus_req_addr  = pick_dat ? dat_addr : fch_addr;
  assign bus_req_write = pick_dat & dat_write;
  assign bus_req_wdata = pick_dat ? dat_wdata : '0;

  assign fch_accept = pick_fch & bus_req_ready;
  assign dat_accept = pick_dat & bus_req_ready;

  assign fch_owns = (owner_q == OWN_FCH);
  assign dat_owns = (owner_q == OWN_DAT);
  assign fch_held = hold_q;

  assign bus_rsp_ready = (fch_owns & fch_rsp_ready) | (dat_owns & dat_rsp_ready);
  assign fch_rsp_hit   = fch_owns & bus_rsp_valid;
  assign dat_rsp_hit   = dat_owns & bus_rsp_valid;
  assign rsp_done      = bus_rsp_valid & bus_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      hold_q  <= 1'b0;
    end else begin
      if (fch_accept)      owner_q <= OWN_FCH;
      else if (dat_accept) owner_q <= OWN_DAT;
      else if (rsp_done)   owner_q <= OWN_NONE;
      hold_q <= pick_fch & ~bus_req_ready;
    end
  end

  // R5: a stalled request is repeated unchanged
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_write) && $stable(bus_req_wdata));

  // R6: one transfer in flight per bus
  assert_one_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready |=> !bus_req_valid);

  // R8: a completed response frees the bus
  assert_rsp_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid && bus_rsp_ready |=> !fch_owns && !dat_owns);

  // R9: prefetch never writes
  assert_fch_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fch_accept |-> !bus_req_write && (bus_req_wdata == '0));
endmodule

// File: rtl/rtr_dual_bus.sv
module rtr_dual_bus
  import rtr_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fch_req_valid,
  output logic              fch_req_ready,
  input  logic [ADDR_W-1:0] fch_req_addr,
  output logic              fch_rsp_valid,
  input  logic              fch_rsp_ready,
  output logic [DATA_W-1:0] fch_rsp_data,
  input  logic              ldst_req_valid,
  output logic              ldst_req_ready,
  input  logic [ADDR_W-1:0] ldst_req_addr,
  input  logic              ldst_req_write,
  input  logic [DATA_W-1:0] ldst_req_wdata,
  output logic              ldst_rsp_valid,
  input  logic              ldst_rsp_ready,
  output logic [DATA_W-1:0] ldst_rsp_data,
  output logic              code_req_valid,
  input  logic              code_req_ready,
  output logic [ADDR_W-1:0] code_req_addr,
  output logic              code_req_write,
  output logic [DATA_W-1:0] code_req_wdata,
  input  logic              code_rsp_valid,
  output logic              code_rsp_ready,
  input  logic [DATA_W-1:0] code_rsp_data,
  output logic              sys_req_valid,
  input  logic              sys_req_ready,
  output logic [ADDR_W-1:0] sys_req_addr,
  output logic              sys_req_write,
  output logic [DATA_W-1:0] sys_req_wdata,
  input  logic              sys_rsp_valid,
  output logic              sys_rsp_ready,
  input  logic [DATA_W-1:0] sys_rsp_data
);
  logic fch_sys, ldst_sys, fch_busy, ldst_busy;

  logic [NUM_BUS-1:0]             l_req_valid, l_req_ready, l_req_write;
  logic [NUM_BUS-1:0][ADDR_W-1:0] l_req_addr;
  logic [NUM_BUS-1:0][DATA_W-1:0] l_req_wdata;
  logic [NUM_BUS-1:0]             l_rsp_valid, l_rsp_ready;
  logic [NUM_BUS-1:0]             l_fch_acc, l_dat_acc, l_fch_hit, l_dat_hit;
  logic [NUM_BUS-1:0]             l_fch_own, l_dat_own, l_fch_held;

  rtr_region_decode #(.ADDR_W(ADDR_W), .CODE_LIMIT(CODE_LIMIT)) u_dec_fch (
    .addr(fch_req_addr), .to_sys(fch_sys));
  rtr_region_decode #(.ADDR_W(ADDR_W), .CODE_LIMIT(CODE_LIMIT)) u_dec_ldst (
    .addr(ldst_req_addr), .to_sys(ldst_sys));

  assign fch_busy  = |l_fch_own;
  assign ldst_busy = |l_dat_own;

  assign l_req_ready[BUS_CODE] = code_req_ready;
  assign l_req_ready[BUS_SYS]  = sys_req_ready;
  assign l_rsp_valid[BUS_CODE] = code_rsp_valid;
  assign l_rsp_valid[BUS_SYS]  = sys_rsp_valid;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
    localparam logic LANE_SYS = (g == BUS_SYS);
    logic fw, dw;
    assign fw = fch_req_valid  & ~fch_busy  & (fch_sys  == LANE_SYS);
    assign dw = ldst_req_valid & ~ldst_busy & (ldst_sys == LANE_SYS);

    rtr_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .fch_want      (fw),
      .dat_want      (dw),
      .fch_addr      (fch_req_addr),
      .dat_addr      (ldst_req_addr),
      .dat_write     (ldst_req_write),
      .dat_wdata     (ldst_req_wdata),
      .bus_req_valid (l_req_valid[g]),
      .bus_req_ready (l_req_ready[g]),
      .bus_req_addr  (l_req_addr[g]),
      .bus_req_write (l_req_write[g]),
      .bus_req_wdata (l_req_wdata[g]),
      .fch_accept    (l_fch_acc[g]),
      .dat_accept    (l_dat_acc[g]),
      .bus_rsp_valid (l_rsp_valid[g]),
      .bus_rsp_ready (l_rsp_ready[g]),
      .fch_rsp_ready (fch_rsp_ready),
      .dat_rsp_ready (ldst_rsp_ready),
      .fch_rsp_hit   (l_fch_hit[g]),
      .dat_rsp_hit   (l_dat_hit[g]),
      .fch_owns      (l_fch_own[g]),
      .dat_owns      (l_dat_own[g]),
      .fch_held      (l_fch_held[g])
    );
  end

  assign code_req_valid = l_req_valid[BUS_CODE];
  assign code_req_addr  = l_req_addr[BUS_CODE];
  assign code_req_write = l_req_write[BUS_CODE];
  assign code_req_wdata = l_req_wdata[BUS_CODE];
  assign code_rsp_ready = l_rsp_ready[BUS_CODE];
  assign sys_req_valid  = l_req_valid[BUS_SYS];
  assign sys_req_addr   = l_req_addr[BUS_SYS];
  assign sys_req_write  = l_req_write[BUS_SYS];
  assign sys_req_wdata  = l_req_wdata[BUS_SYS];
  assign sys_rsp_ready  = l_rsp_ready[BUS_SYS];

  assign fch_req_ready  = |l_fch_acc;
  assign ldst_req_ready = |l_dat_acc;

  assign fch_rsp_valid  = |l_fch_hit;
  assign fch_rsp_data   = l_fch_own[BUS_SYS] ? sys_rsp_data : code_rsp_data;
  assign ldst_rsp_valid = |l_dat_hit;
  assign ldst_rsp_data  = l_dat_own[BUS_SYS] ? sys_rsp_data : code_rsp_data;

  // R7: the prefetch port never holds two transfers
  assert_fch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(l_fch_own) <= 1);

  // R3: different buses, both idle and ready -> both accepted together
  assert_parallel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fch_req_valid && ldst_req_valid && (fch_sys != ldst_sys)
      && (l_fch_own == '0) && (l_dat_own == '0) && code_req_ready && sys_req_ready
      |-> fch_req_ready && ldst_req_ready);

  // R4: same bus, fresh contention -> prefetch waits
  assert_data_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ldst_req_valid && !ldst_busy && fch_req_valid && (fch_sys == ldst_sys)
      && !l_fch_held[ldst_sys] |-> !fch_req_ready);
endmodule

// File: tb/tb_rtr_dual_bus.sv
`timescale 1ns/1ps
module tb_rtr_dual_bus;
  localparam logic [31:0] LIMIT = 32'h2000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic fch_req_valid, fch_req_ready, fch_rsp_valid, fch_rsp_ready;
  logic [31:0] fch_req_addr, fch_rsp_data;
  logic ldst_req_valid, ldst_req_ready, ldst_req_write, ldst_rsp_valid, ldst_rsp_ready;
  logic [31:0] ldst_req_addr, ldst_req_wdata, ldst_rsp_data;
  logic code_req_valid, code_req_ready, code_req_write, code_rsp_valid, code_rsp_ready;
  logic [31:0] code_req_addr, code_req_wdata, code_rsp_data;
  logic sys_req_valid, sys_req_ready, sys_req_write, sys_rsp_valid, sys_rsp_ready;
  logic [31:0] sys_req_addr, sys_req_wdata, sys_rsp_data;

  rtr_dual_bus dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle_inputs();
    fch_req_valid = 0; fch_req_addr = 0; fch_rsp_ready = 0;
    ldst_req_valid = 0; ldst_req_addr = 0; ldst_req_write = 0; ldst_req_wdata = 0;
    ldst_rsp_ready = 0;
    code_req_ready = 0; code_rsp_valid = 0; code_rsp_data = 0;
    sys_req_ready = 0; sys_rsp_valid = 0; sys_rsp_data = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] tag(input int b);
    return b ? 32'h5A5A_0000 : 32'h0000_A5A5;
  endfunction

  function automatic logic [31:0] rand_addr();
    int k = int'($urandom % 6);
    case (k)
      0: return 32'h1FFF_FFFC;
      1: return LIMIT;
      2: return $urandom % LIMIT;
      3: return 32'hFFFF_FFFC;
      default: return $urandom;
    endcase
  endfunction

  // reference model and agent state
  int own[2]; bit lock[2]; int pick[2];
  bit s_busy[2]; int s_lat[2]; logic [31:0] s_addr[2], s_wd[2];
  bit s_rv[2]; logic [31:0] s_rd[2]; bit s_rdy[2];
  bit f_req, f_out; logic [31:0] f_addr, f_oaddr;
  bit d_req, d_out, d_wr; logic [31:0] d_addr, d_wd, d_oaddr, d_owd;

  initial begin
    do_reset();
    #1;
    // R10: quiet after reset
    chk("R10", "code_req_valid", code_req_valid, 0);
    chk("R10", "sys_req_valid", sys_req_valid, 0);
    chk("R10", "fch_req_ready", fch_req_ready, 0);
    chk("R10", "ldst_req_ready", ldst_req_ready, 0);
    chk("R10", "fch_rsp_valid", fch_rsp_valid, 0);
    chk("R10", "ldst_rsp_valid", ldst_rsp_valid, 0);
    chk("R10", "code_rsp_ready", code_rsp_ready, 0);
    chk("R10", "sys_rsp_ready", sys_rsp_ready, 0);

    // R4: both to code bus in the same cycle
    @(negedge clk);
    code_req_ready = 1; sys_req_ready = 1;
    fch_req_valid = 1; fch_req_addr = 32'h100;
    ldst_req_valid = 1; ldst_req_addr = 32'h200; ldst_req_write = 1; ldst_req_wdata = 32'hDEAD_BEEF;
    #1;
    chk("R4", "ldst_req_ready", ldst_req_ready, 1);
    chk("R4", "fch_req_ready", fch_req_ready, 0);
    chk("R4", "code_req_addr", code_req_addr, 32'h200);
    chk("R4", "code_req_write", code_req_write, 1);
    chk("R1", "sys_req_valid", sys_req_valid, 0);

    @(negedge clk); ldst_req_valid = 0; #1;
    chk("R6", "code_req_valid busy", code_req_valid, 0);
    chk("R6", "fch_req_ready busy", fch_req_ready, 0);

    @(negedge clk);
    code_rsp_valid = 1; code_rsp_data = 32'h1234_5678; ldst_rsp_ready = 1; fch_rsp_ready = 1; #1;
    chk("R8", "ldst_rsp_valid", ldst_rsp_valid, 1);
    chk("R8", "ldst_rsp_data", ldst_rsp_data, 32'h1234_5678);
    chk("R8", "fch_rsp_valid", fch_rsp_valid, 0);
    chk("R8", "code_rsp_ready", code_rsp_ready, 1);

    @(negedge clk); code_rsp_valid = 0; code_req_ready = 0; #1;
    chk("R9", "code_req_valid", code_req_valid, 1);
    chk("R9", "code_req_addr", code_req_addr, 32'h100);
    chk("R9", "code_req_write", code_req_write, 0);
    chk("R9", "code_req_wdata", code_req_wdata, 0);
    chk("R5", "fch_req_ready stalled", fch_req_ready, 0);

    @(negedge clk);
    ldst_req_valid = 1; ldst_req_addr = 32'h300; ldst_req_write = 0; ldst_req_wdata = 0; #1;
    chk("R5", "code_req_addr kept", code_req_addr, 32'h100);
    chk("R5", "code_req_write kept", code_req_write, 0);
    chk("R5", "ldst_req_ready", ldst_req_ready, 0);

    @(negedge clk); code_req_ready = 1; #1;
    chk("R5", "fch_req_ready", fch_req_ready, 1);
    chk("R5", "ldst_req_ready", ldst_req_ready, 0);

    @(negedge clk); fch_req_valid = 0; #1;
    chk("R6", "code_req_valid owned", code_req_valid, 0);
    chk("R6", "ldst_req_ready", ldst_req_ready, 0);

    @(negedge clk); code_rsp_valid = 1; code_rsp_data = 32'hCAFE_0001; fch_rsp_ready = 0; #1;
    chk("R8", "fch_rsp_valid", fch_rsp_valid, 1);
    chk("R8", "code_rsp_ready stalled", code_rsp_ready, 0);
    chk("R8", "ldst_rsp_valid", ldst_rsp_valid, 0);

    @(negedge clk); fch_rsp_ready = 1; #1;
    chk("R8", "code_rsp_ready", code_rsp_ready, 1);
    chk("R8", "fch_rsp_data", fch_rsp_data, 32'hCAFE_0001);

    @(negedge clk); code_rsp_valid = 0; #1;
    chk("R4", "ldst_req_ready later", ldst_req_ready, 1);
    chk("R1", "code_req_addr", code_req_addr, 32'h300);

    @(negedge clk); ldst_req_valid = 0; code_rsp_valid = 1; code_rsp_data = 32'h77; #1;
    chk("R8", "ldst_rsp_valid", ldst_rsp_valid, 1);

    // R3 with split-point addresses, cross-region use
    @(negedge clk);
    code_rsp_valid = 0;
    fch_req_valid = 1; fch_req_addr = 32'h2000_0000;
    ldst_req_valid = 1; ldst_req_addr = 32'h1FFF_FFFC; ldst_req_write = 1; ldst_req_wdata = 32'h0BAD_F00D;
    #1;
    chk("R3", "fch_req_ready", fch_req_ready, 1);
    chk("R3", "ldst_req_ready", ldst_req_ready, 1);
    chk("R2", "sys_req_addr", sys_req_addr, 32'h2000_0000);
    chk("R1", "code_req_addr", code_req_addr, 32'h1FFF_FFFC);

    @(negedge clk); ldst_req_valid = 0; code_rsp_valid = 1; ldst_rsp_ready = 1;
    fch_req_addr = 32'h40; #1;
    chk("R8", "ldst_rsp_valid", ldst_rsp_valid, 1);

    @(negedge clk); code_rsp_valid = 0; #1;
    chk("R7", "fch_req_ready busy port", fch_req_ready, 0);
    chk("R7", "code_req_valid", code_req_valid, 0);

    // random phase with per-cycle reference model
    do_reset();
    for (int b = 0; b < 2; b++) begin
      own[b] = 0; lock[b] = 0; s_busy[b] = 0; s_rv[b] = 0; s_lat[b] = 0;
    end
    f_req = 0; f_out = 0; d_req = 0; d_out = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit fsel, dsel, fbusy, dbusy, fw, dw;
      bit e_frdy, e_drdy, e_frv, e_drv;
      bit e_rsprdy[2];
      logic [31:0] e_frd, e_drd;
      if (cyc != 0) @(negedge clk);
      // agents choose this cycle's inputs
      if (!f_req && ($urandom % 3 == 0)) begin f_req = 1; f_addr = rand_addr(); end
      if (!d_req && ($urandom % 3 == 0)) begin
        d_req = 1; d_addr = rand_addr(); d_wr = $urandom; d_wd = $urandom;
      end
      for (int b = 0; b < 2; b++) begin
        s_rdy[b] = ($urandom % 3 != 0);
        if (s_busy[b]) begin
          if (!s_rv[b]) begin
            if (s_lat[b] == 0) begin s_rv[b] = 1; s_rd[b] = s_addr[b] ^ s_wd[b] ^ tag(b); end
            else s_lat[b]--;
          end
        end else begin
          s_rv[b] = ($urandom % 8 == 0); s_rd[b] = $urandom;
        end
      end
      fch_req_valid = f_req; fch_req_addr = f_addr; fch_rsp_ready = ($urandom % 4 != 0);
      ldst_req_valid = d_req; ldst_req_addr = d_addr; ldst_req_write = d_wr;
      ldst_req_wdata = d_wd; ldst_rsp_ready = ($urandom % 4 != 0);
      code_req_ready = s_rdy[0]; code_rsp_valid = s_rv[0]; code_rsp_data = s_rd[0];
      sys_req_ready = s_rdy[1]; sys_rsp_valid = s_rv[1]; sys_rsp_data = s_rd[1];
      #1;
      // expected behaviour
      fsel = (f_addr >= LIMIT); dsel = (d_addr >= LIMIT);
      fbusy = (own[0] == 1) || (own[1] == 1);
      dbusy = (own[0] == 2) || (own[1] == 2);
      fw = f_req && !fbusy; dw = d_req && !dbusy;
      e_frv = 0; e_drv = 0; e_frd = 0; e_drd = 0;
      for (int b = 0; b < 2; b++) begin
        pick[b] = 0;
        if (own[b] == 0) begin
          if (lock[b]) pick[b] = 1;
          else if (dw && (dsel == b[0])) pick[b] = 2;
          else if (fw && (fsel == b[0])) pick[b] = 1;
        end
        e_rsprdy[b] = (own[b] == 1) ? fch_rsp_ready : (own[b] == 2) ? ldst_rsp_ready : 0;
        if (own[b] == 1 && s_rv[b]) begin e_frv = 1; e_frd = s_rd[b]; end
        if (own[b] == 2 && s_rv[b]) begin e_drv = 1; e_drd = s_rd[b]; end
      end
      e_frdy = (pick[fsel] == 1) && s_rdy[fsel];
      e_drdy = (pick[dsel] == 2) && s_rdy[dsel];
      begin
        logic [31:0] xa, xd; logic xv, xw;
        for (int b = 0; b < 2; b++) begin
          string rt = (b == 0) ? "R1" : "R2";
          xv = b ? sys_req_valid : code_req_valid;
          xa = b ? sys_req_addr : code_req_addr;
          xw = b ? sys_req_write : code_req_write;
          xd = b ? sys_req_wdata : code_req_wdata;
          chk(own[b] != 0 ? "R6" : rt, "bus req_valid", xv, pick[b] != 0);
          if (pick[b] != 0) begin
            chk(lock[b] ? "R5" : rt, "bus req_addr", xa, pick[b] == 2 ? d_addr : f_addr);
            chk(pick[b] == 1 ? "R9" : rt, "bus req_write", xw, pick[b] == 2 ? d_wr : 1'b0);
            chk(pick[b] == 1 ? "R9" : rt, "bus req_wdata", xd, pick[b] == 2 ? d_wd : 32'h0);
          end
          chk("R8", "bus rsp_ready", b ? sys_rsp_ready : code_rsp_ready, e_rsprdy[b]);
        end
      end
      chk(fbusy && f_req ? "R7" : (e_frdy && e_drdy) ? "R3" : "R4", "fch_req_ready", fch_req_ready, e_frdy);
      chk(dbusy && d_req ? "R7" : (e_frdy && e_drdy) ? "R3" : "R4", "ldst_req_ready", ldst_req_ready, e_drdy);
      chk("R8", "fch_rsp_valid", fch_rsp_valid, e_frv);
      chk("R8", "ldst_rsp_valid", ldst_rsp_valid, e_drv);
      if (e_frv) chk("R8", "fch_rsp_data", fch_rsp_data, e_frd);
      if (e_drv) chk("R8", "ldst_rsp_data", ldst_rsp_data, e_drd);
      // end-to-end response data proves the region routing
      if (e_frv && fch_rsp_ready) begin
        chk(f_oaddr >= LIMIT ? "R2" : "R1", "fch end-to-end data", e_frd,
            f_oaddr ^ tag(f_oaddr >= LIMIT));
        f_out = 0;
      end
      if (e_drv && ldst_rsp_ready) begin
        chk(d_oaddr >= LIMIT ? "R2" : "R1", "ldst end-to-end data", e_drd,
            d_oaddr ^ d_owd ^ tag(d_oaddr >= LIMIT));
        d_out = 0;
      end
      if (e_frdy) begin f_req = 0; f_out = 1; f_oaddr = f_addr; end
      if (e_drdy) begin d_req = 0; d_out = 1; d_oaddr = d_addr; d_owd = d_wr ? d_wd : 32'h0; end
      // model state update for the coming edge
      for (int b = 0; b < 2; b++) begin
        if (own[b] != 0 && s_rv[b] && e_rsprdy[b]) begin
          own[b] = 0; s_busy[b] = 0; s_rv[b] = 0;
        end else if (!s_busy[b]) s_rv[b] = 0;
        if (pick[b] != 0 && s_rdy[b]) begin
          own[b] = pick[b]; lock[b] = 0;
          s_busy[b] = 1; s_rv[b] = 0; s_lat[b] = int'($urandom % 4);
          s_addr[b] = (pick[b] == 2) ? d_addr : f_addr;
          s_wd[b] = (pick[b] == 2 && d_wr) ? d_wd : 32'h0;
        end else lock[b] = (pick[b] == 1);
      end
    end
    finish_run();
  end
endmodule